// File: doc/BRIEF.md
# Oversampled SPI Slave Byte Port

This block is a mode-0 SPI slave in which all state lives in the system clock domain. The serial clock, data-in line and active-low select come in as ordinary inputs. Each one passes through a synchronizer, and SCK edges are found by comparing successive synchronized samples. No flop is clocked by SCK. One byte moves per transfer, most significant bit first, in both directions at once.

The host side has three parts:
- a write port that loads the next byte to send;
- a read port that shows the last byte received;
- three flags (transfer done, write collision, overrun) and an interrupt output gated by an enable input.

The send side shares a single register with the shifter. The receive side has its own holding register, so a finished byte stays readable while the next one is shifted in.

Top module: `spi_slave_os`

## Requirements
- R1: Data on `mosiIn` is captured at each detected rising edge of `sckIn`, first bit as bit 7. After the eighth rising edge in a selection, the full byte appears on `rdData`.
- R2: While selected and before the first rising edge of a byte, `misoOut` shows bit 7 of the loaded send byte. Each detected falling edge inside the byte advances `misoOut` to the next lower bit.
- R3: Completing a byte sets `doneFlag`. `irq` is high exactly when `doneFlag` and `intEn` are both high.
- R4: `rdData` changes only when a byte completes. It holds the previous byte while a new byte is partly shifted in.
- R5: A host write while selected-and-idle or deselected loads the send byte. This holds even if the received byte is still unread, and `rdData` is left untouched.
- R6: A host write while a byte is partly shifted (select low, bit count nonzero) is ignored by the shifter and sets the sticky `collFlag`.
- R7: If a byte completes while `doneFlag` is still set, `ovrFlag` is set. `rdData` then holds the newest byte, and the older one is lost.
- R8: A pulse on `rdEn` clears `doneFlag`, `ovrFlag` and `collFlag`. `rdData` keeps its value.
- R9: Raising `ssNIn` mid-byte discards the partial byte without setting `doneFlag`. The next full byte is received correctly.
- R10: While `ssNIn` is high (deselected), `misoOut` is 0.
- R11: When no new send byte is written after a completed transfer, the shifter holds the received byte, and the next transfer sends it back.
- R12: After reset, `doneFlag`, `collFlag`, `ovrFlag`, `irq`, `misoOut` and `rdData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | Serial clock from the bus master |
| mosiIn | input | 1 | Serial data from the master |
| ssNIn | input | 1 | Active-low slave select |
| misoOut | output | 1 | Serial data to the master |
| wrEn | input | 1 | Host write strobe for the send byte |
| wrData | input | DATA_W | Send byte to load |
| rdEn | input | 1 | Host read strobe; clears the flags |
| rdData | output | DATA_W | Last received byte |
| intEn | input | 1 | Interrupt enable |
| doneFlag | output | 1 | Byte transfer complete |
| collFlag | output | 1 | Sticky write collision |
| ovrFlag | output | 1 | Receive overrun |
| irq | output | 1 | Interrupt request |

## Verification
Every serial pin reaches the logic three system clocks after it toggles: two synchronizer stages and one edge-detect register. This means `rdData`, `doneFlag` and `ovrFlag` settle three clocks after the eighth SCK rise, and `misoOut` moves three clocks after an SCK fall. Host writes and read-clears act one clock after their strobe. The bench changes pins on falling clock edges and holds each SCK phase for at least four clocks. It samples `misoOut` four clocks after each fall and checks flags and data at least five clocks after the final rise, so every sample lands after its result is due.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;

  // Strobes handed from the control section to the datapath
  typedef struct packed {
    logic selected;  // synchronized select is active
    logic sample;    // rising SCK edge while selected
    logic shift;     // falling SCK edge inside a byte
    logic complete;  // rising SCK edge that ends a byte
    logic loadTx;    // accepted host write
    logic mosiBit;   // synchronized serial input
  } dpStrb_t;

endpackage

// File: rtl/spi_os_ctrl.sv
module spi_os_ctrl
  import spi_os_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sckIn,
  input  logic    mosiIn,
  input  logic    ssNIn,
  input  logic    wrEn,
  input  logic    rdEn,
  input  logic    intEn,
  output dpStrb_t strb,
  output logic    doneFlag,
  output logic    collFlag,
  output logic    ovrFlag,
  output logic    irq
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sckSh, mosiSh, ssSh;
  logic sckPrev;
  logic sckS, mosiS, ssS;
  logic rise, fall, selected, busy;
  logic [CNT_W-1:0] bitCnt;

  // Synchronizer chains for the three serial pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSh   <= '0;
      mosiSh  <= '0;
      ssSh    <= '1;
      sckPrev <= 1'b0;
    end else begin
      sckSh   <= {sckSh[SYNC_STAGES-2:0], sckIn};
      mosiSh  <= {mosiSh[SYNC_STAGES-2:0], mosiIn};
      ssSh    <= {ssSh[SYNC_STAGES-2:0], ssNIn};
      sckPrev <= sckS;
    end
  end

  assign sckS     = sckSh[SYNC_STAGES-1];
  assign mosiS    = mosiSh[SYNC_STAGES-1];
  assign ssS      = ssSh[SYNC_STAGES-1];
  assign rise     = sckS & ~sckPrev;
  assign fall     = ~sckS & sckPrev;
  assign selected = ~ssS;
  assign busy     = selected && (bitCnt != '0);

  // Bit position within the current byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (!selected) begin
      bitCnt <= '0;
    end else if (rise) begin
      bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
    end
  end

  always_comb begin
    strb.selected = selected;
    strb.sample   = selected & rise;
    strb.shift    = selected & fall & (bitCnt != '0);
    strb.complete = selected & rise & (bitCnt == LAST_BIT);
    strb.loadTx   = wrEn & ~busy;
    strb.mosiBit  = mosiS;
  end

  // Host-visible flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      ovrFlag  <= 1'b0;
      collFlag <= 1'b0;
    end else begin
      if (strb.complete)   doneFlag <= 1'b1;
      else if (rdEn)       doneFlag <= 1'b0;

      if (strb.complete && doneFlag && !rdEn) ovrFlag <= 1'b1;
      else if (rdEn)                          ovrFlag <= 1'b0;

      if (wrEn && busy)    collFlag <= 1'b1;
      else if (rdEn)       collFlag <= 1'b0;
    end
  end

  assign irq = doneFlag & intEn;

endmodule

// File: rtl/spi_os_dp.sv
module spi_os_dp
  import spi_os_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrb_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              misoOut
);

  logic [DATA_W-1:0] shiftReg, holdReg, rxByte;
  logic rxBit;

  assign rxByte = {shiftReg[DATA_W-2:0], strb.mosiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBit    <= 1'b0;
      shiftReg <= '0;
      holdReg  <= '0;
    end else begin
      if (strb.sample) rxBit <= strb.mosiBit;

      // loadTx only when idle; complete and shift only mid-byte
      if (strb.loadTx)        shiftReg <= wrData;
      else if (strb.complete) shiftReg <= rxByte;
      else if (strb.shift)    shiftReg <= {shiftReg[DATA_W-2:0], rxBit};

      if (strb.complete) holdReg <= rxByte;
    end
  end

  assign rdData  = holdReg;
  assign misoOut = strb.selected ? shiftReg[DATA_W-1] : 1'b0;

endmodule

// File: rtl/spi_slave_os.sv
module spi_slave_os
  import spi_os_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              ssNIn,
  output logic              misoOut,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              intEn,
  output logic              doneFlag,
  output logic              collFlag,
  output logic              ovrFlag,
  output logic              irq
);

  dpStrb_t strb;

  spi_os_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .mosiIn(mosiIn), .ssNIn(ssNIn),
    .wrEn(wrEn), .rdEn(rdEn), .intEn(intEn), .strb(strb),
    .doneFlag(doneFlag), .collFlag(collFlag), .ovrFlag(ovrFlag), .irq(irq)
  );

  spi_os_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdData(rdData), .misoOut(misoOut)
  );

endmodule

// File: rtl/spi_os_chk.sv
module spi_os_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ssNIn,
  input logic              wrEn,
  input logic              rdEn,
  input logic              misoOut,
  input logic [DATA_W-1:0] rdData,
  input logic              doneFlag,
  input logic              collFlag,
  input logic              ovrFlag,
  input logic              complete
);

  assert_done_after_byte_R3: assert property (@(posedge clk) disable iff (!rstN)
    complete |=> doneFlag);

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !complete |=> $stable(rdData));

  assert_coll_needs_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(collFlag) |-> $past(wrEn));

  assert_ovr_needs_unread_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(doneFlag));

  assert_done_clear_by_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneFlag) |-> $past(rdEn));

  assert_miso_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ssNIn && $past(ssNIn) && $past(ssNIn, 2)) |-> !misoOut);

endmodule

bind spi_slave_os spi_os_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ssNIn(ssNIn), .wrEn(wrEn), .rdEn(rdEn),
  .misoOut(misoOut), .rdData(rdData), .doneFlag(doneFlag),
  .collFlag(collFlag), .ovrFlag(ovrFlag), .complete(strb.complete)
);

// File: tb/tb_spi_slave_os.sv
module tb_spi_slave_os;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, mosiIn = 1'b0, ssNIn = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0, intEn = 1'b0;
  logic [7:0] wrData = '0;
  logic misoOut, doneFlag, collFlag, ovrFlag, irq;
  logic [7:0] rdData;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;
  logic [7:0] gotMiso;

  always #4 clk = ~clk;

  spi_slave_os dut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .mosiIn(mosiIn), .ssNIn(ssNIn),
    .misoOut(misoOut), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .intEn(intEn), .doneFlag(doneFlag),
    .collFlag(collFlag), .ovrFlag(ovrFlag), .irq(irq)
  );

  // {intEn, send byte, byte the master sends}
  localparam logic [16:0] VEC [4] = '{
    {1'b0, 8'hA5, 8'h3C},
    {1'b1, 8'h5A, 8'hC3},
    {1'b1, 8'hFF, 8'h00},
    {1'b0, 8'h01, 8'h80}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [7:0] b);
    @(negedge clk); wrEn = 1'b1; wrData = b;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic hostRead();
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  // Shift nBits of mo; optionally write collByte after bit collideAt
  task automatic xfer(input logic [7:0] mo, input int nBits,
                      input int collideAt, input logic [7:0] collByte);
    gotMiso = '0;
    for (int i = 0; i < nBits; i++) begin
      @(negedge clk); mosiIn = mo[7-i];
      idle(3);
      gotMiso = {gotMiso[6:0], misoOut};
      @(negedge clk); sckIn = 1'b1;
      idle(4);
      @(negedge clk); sckIn = 1'b0;
      if (i == collideAt) hostWrite(collByte);
    end
    idle(5);
  endtask

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(2);
    // R12 reset state
    chk("R12 done", doneFlag, 0);
    chk("R12 coll", collFlag, 0);
    chk("R12 ovr", ovrFlag, 0);
    chk("R12 irq", irq, 0);
    chk("R12 miso", misoOut, 0);
    chk("R12 rdData", rdData, 0);

    // R10 deselected output stays low even with a loaded 1
    hostWrite(8'hFF);
    idle(3);
    chk("R10 miso deselected", misoOut, 0);

    ssNIn = 1'b0;
    idle(4);

    // Vector table: R1 R2 R3 R8
    for (int v = 0; v < 4; v++) begin
      intEn = VEC[v][16];
      hostWrite(VEC[v][15:8]);
      idle(2);
      chk("R2 msb before first edge", misoOut, VEC[v][15]);
      xfer(VEC[v][7:0], 8, -1, 8'h00);
      chk("R2 miso bits", gotMiso, VEC[v][15:8]);
      chk("R1 rdData", rdData, VEC[v][7:0]);
      chk("R3 done", doneFlag, 1);
      chk("R3 irq", irq, VEC[v][16]);
      hostRead();
      chk("R8 done cleared", doneFlag, 0);
    end
    intEn = 1'b1;

    // R5: load while the received byte is unread; R7 overrun
    hostWrite(8'h81);
    xfer(8'h5A, 8, -1, 8'h00);
    hostWrite(8'h42);
    idle(1);
    chk("R5 rdData kept", rdData, 8'h5A);
    chk("R5 new msb", misoOut, 0);
    xfer(8'h17, 8, -1, 8'h00);
    chk("R5 sent new byte", gotMiso, 8'h42);
    chk("R7 ovr", ovrFlag, 1);
    chk("R7 newest kept", rdData, 8'h17);
    hostRead();
    chk("R8 ovr cleared", ovrFlag, 0);

    // R4 hold during partial byte, R9 abort
    hostWrite(8'h00);
    xfer(8'h66, 8, -1, 8'h00);
    hostRead();
    chk("R8 rdData kept after read", rdData, 8'h66);
    xfer(8'h99, 4, -1, 8'h00);
    chk("R4 hold mid byte", rdData, 8'h66);
    ssNIn = 1'b1;
    idle(6);
    chk("R9 no done on abort", doneFlag, 0);
    chk("R10 miso after abort", misoOut, 0);
    ssNIn = 1'b0;
    idle(4);
    hostWrite(8'hE7);
    xfer(8'h24, 8, -1, 8'h00);
    chk("R9 rx after abort", rdData, 8'h24);
    chk("R9 tx after abort", gotMiso, 8'hE7);
    hostRead();

    // R11 echo of received byte
    xfer(8'h00, 8, -1, 8'h00);
    chk("R11 echo", gotMiso, 8'h24);
    hostRead();

    // R6 collision
    hostWrite(8'hB2);
    xfer(8'h11, 8, 2, 8'hCD);
    chk("R6 coll set", collFlag, 1);
    chk("R6 tx unchanged", gotMiso, 8'hB2);
    chk("R6 rdData", rdData, 8'h11);
    chk("R6 shifter not loaded", misoOut, 0);
    hostRead();
    chk("R8 coll cleared", collFlag, 0);
    chk("R8 ovr clear", ovrFlag, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule